// File: doc/BRIEF.md
# Split Precision Gamma Palette

A register-programmed colour lookup memory for a display pipe. Each entry holds one 30-bit RGB word with ten bits per channel. Software loads entries through two registers: an index register that points at an entry, and a data register whose writes store the word at that entry. The index register also carries an auto-increment enable and a split flag. With auto-increment on, each data write moves the index forward by one, so a whole table loads as a burst of data writes.

The same storage serves three lookup modes. In legacy mode and full 10-bit mode, the memory is one table indexed by the top bits of each pixel channel. In split mode, the lower half holds a degamma table and the upper half, starting at index DEPTH/2, holds a gamma table. Each channel goes first through the degamma half and then through the gamma half. A channel code at or above 1.0 skips the table and returns that channel's 16-bit maximum register. Lookup results appear two clock cycles after the pixel is presented, whatever the mode.

After reset the table holds a linear ramp on all three channels, and the maximum registers hold 0xFFFF. Software is expected to set the index back to 0 after a load. The index register can be read back at any time.

Top module: `gamma_split_palette`

## Requirements
- R1: After reset, the index is 0, auto-increment and split are clear, the mode is 0, all three maximum registers read 0xFFFF, and entry i holds floor(i*1023/(DEPTH-1)) on every channel.
- R2: A write to the data register (address 1) stores wdata[29:20] as red, wdata[19:10] as green and wdata[9:0] as blue at the current index. A read of address 1 returns the entry at the current index in the same packing and leaves the index unchanged.
- R3: With auto-increment set, each data write advances the index by one. With it clear, data writes leave the index unchanged.
- R4: Without the split flag, an auto-increment data write at index DEPTH-1 wraps the index to 0.
- R5: With the split flag set, auto-increment stays inside the half that holds the index: DEPTH/2-1 wraps to 0, and DEPTH-1 wraps to DEPTH/2.
- R6: The index register (address 0) holds the index in bits [AW-1:0], auto-increment in bit 15 and split in bit 31. Writing it loads all three fields, and reading it returns them.
- R7: In mode 1 (full 10-bit), a channel code c below 1024 gives {E, 6'b0}, where E is that channel's field of entry c[9:10-AW].
- R8: In mode 2 (split), a channel code c below 1024 first reads D, that channel's field of entry c[9:11-AW] in the lower half. It then gives {G, 6'b0}, where G is that channel's field of entry DEPTH/2 + D[9:11-AW].
- R9: In mode 0 (legacy 8-bit), a channel code c below 1024 gives {E[9:2], 8'b0}, with E taken as in R7.
- R10: A channel code of 1024 or more gives that channel's maximum register in every mode. The maximum registers sit at address 4 (red), 5 (green) and 6 (blue) and hold wdata[15:0].
- R11: The mode register (address 2) holds bits [1:0]. Value 3 behaves like value 0.
- R12: out_valid is high exactly two cycles after pix_valid was high and low otherwise, and outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| pix_valid | input | 1 | Pixel lookup request |
| pix_r | input | IN_W | Red code, 1024 = 1.0 |
| pix_g | input | IN_W | Green code |
| pix_b | input | IN_W | Blue code |
| out_valid | output | 1 | Lookup result valid |
| out_r | output | 16 | Red result |
| out_g | output | 16 | Green result |
| out_b | output | 16 | Blue result |

## Verification
On every cycle, the assertions check how the index moves: it steps by one, holds when auto-increment is off, wraps at the top, and stays in its segment in split mode. They also check the fixed two-cycle result latency, that out-of-range codes take the maximum value, and the zero low bits that each mode's precision implies. Only the bench scenarios can show that the right entries are fetched. That covers the reset ramp content, the packing of stored words, the two-stage degamma-to-gamma cascade in split mode, and that mode 3 behaves as legacy. The bench checks these against its own model of the table, filled with random data.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

    localparam int CH_W  = 10;
    localparam int NCH   = 3;
    localparam int OUT_W = 16;

    localparam int AUTO_BIT  = 15;
    localparam int SPLIT_BIT = 31;

    localparam logic [2:0] A_INDEX = 3'd0;
    localparam logic [2:0] A_DATA  = 3'd1;
    localparam logic [2:0] A_MODE  = 3'd2;
    localparam logic [2:0] A_MAX0  = 3'd4;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        MODE_LEGACY8    = 2'd0,
        MODE_FULL10     = 2'd1,
        MODE_SPLIT      = 2'd2,
        MODE_LEGACY_ALT = 2'd3
    } mode_e;

    function automatic logic [CH_W-1:0] ramp_val(input int i, input int depth);
        int v;
        v = (i * ((1 << CH_W) - 1)) / (depth - 1);
        return CH_W'(v);
    endfunction

    function automatic logic [CH_W-1:0] chan_of(input rgb_t e, input int c);
        case (c)
            0:       return e.r;
            1:       return e.g;
            default: return e.b;
        endcase
    endfunction

    function automatic logic is_legacy(input mode_e m);
        return (m == MODE_LEGACY8) || (m == MODE_LEGACY_ALT);
    endfunction

endpackage

// File: rtl/gsp_lut_mem.sv
module gsp_lut_mem
    import gsp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NRD   = 7,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  rgb_t          wr_data,
    input  logic [AW-1:0] rd_idx [NRD],
    output rgb_t          rd_data [NRD]
);

    rgb_t cells [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[e] <= '{r: ramp_val(e, DEPTH),
                              g: ramp_val(e, DEPTH),
                              b: ramp_val(e, DEPTH)};
            end else if (wr_en && (wr_idx == AW'(e))) begin
                cells[e] <= wr_data;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = cells[rd_idx[p]];
    end

endmodule

// File: rtl/gsp_ctrl_regs.sv
module gsp_ctrl_regs
    import gsp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             mem_we,
    output logic [AW-1:0]    mem_widx,
    output rgb_t             mem_wdata,
    output logic [AW-1:0]    mem_ridx,
    input  rgb_t             mem_rent,
    output mode_e            mode,
    output logic [OUT_W-1:0] max_v [NCH]
);

    logic [AW-1:0] idx_q;
    logic          auto_q;
    logic          split_q;
    logic          data_wr;
    logic [AW-1:0] idx_next;

    assign data_wr = we && (addr == A_DATA);

    // split keeps the half-select bit and steps within the half
    always_comb begin
        if (split_q)
            idx_next = {idx_q[AW-1], idx_q[AW-2:0] + 1'b1};
        else
            idx_next = idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            auto_q  <= 1'b0;
            split_q <= 1'b0;
        end else if (we && (addr == A_INDEX)) begin
            idx_q   <= wdata[AW-1:0];
            auto_q  <= wdata[AUTO_BIT];
            split_q <= wdata[SPLIT_BIT];
        end else if (data_wr && auto_q) begin
            idx_q <= idx_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= MODE_LEGACY8;
        else if (we && (addr == A_MODE))
            mode <= mode_e'(wdata[1:0]);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_max
        always_ff @(posedge clk) begin
            if (rst)
                max_v[c] <= '1;
            else if (we && (addr == A_MAX0 + 3'(c)))
                max_v[c] <= wdata[OUT_W-1:0];
        end
    end

    assign mem_we    = data_wr;
    assign mem_widx  = idx_q;
    assign mem_wdata = rgb_t'(wdata[3*CH_W-1:0]);
    assign mem_ridx  = idx_q;

    always_comb begin
        rdata = '0;
        case (addr)
            A_INDEX: begin
                rdata[AW-1:0]    = idx_q;
                rdata[AUTO_BIT]  = auto_q;
                rdata[SPLIT_BIT] = split_q;
            end
            A_DATA:  rdata[3*CH_W-1:0] = mem_rent;
            A_MODE:  rdata[1:0] = mode;
            3'd4:    rdata[OUT_W-1:0] = max_v[0];
            3'd5:    rdata[OUT_W-1:0] = max_v[1];
            3'd6:    rdata[OUT_W-1:0] = max_v[2];
            default: rdata = '0;
        endcase
    end

    logic unused_wd;
    assign unused_wd = ^wdata[SPLIT_BIT-1:3*CH_W];

    // R3: auto-increment steps by one away from a wrap point
    p_idx_step_r3: assert property (@(posedge clk) disable iff (rst)
        (data_wr && auto_q && !split_q && (idx_q != '1))
        |=> (idx_q == $past(idx_q) + 1'b1));

    // R3: without auto-increment the index holds
    p_idx_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !auto_q) |=> $stable(idx_q));

    // R4: top of table wraps to zero
    p_idx_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (data_wr && auto_q && !split_q && (idx_q == '1)) |=> (idx_q == '0));

    // R5: split mode never leaves the current half
    p_seg_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (data_wr && auto_q && split_q)
        |=> (idx_q[AW-1] == $past(idx_q[AW-1])));

endmodule

// File: rtl/gsp_lookup.sv
module gsp_lookup
    import gsp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IN_W  = CH_W + 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode,
    input  logic [OUT_W-1:0] max_v [NCH],
    input  logic             pix_valid,
    input  logic [IN_W-1:0]  pix [NCH],
    output logic [AW-1:0]    rd_idx [2*NCH],
    input  rgb_t             rd_ent [2*NCH],
    output logic             out_valid,
    output logic [OUT_W-1:0] out_v [NCH]
);

    localparam int PAD_FULL = OUT_W - CH_W;
    localparam int PAD_LEG  = OUT_W - 8;

    logic  s1_valid;
    mode_e s1_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1_mode   <= MODE_LEGACY8;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= pix_valid;
            out_valid <= s1_valid;
            if (pix_valid)
                s1_mode <= mode;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic            over;
        logic            s1_over;
        logic [CH_W-1:0] s1_val;
        logic [CH_W-1:0] deg_v;
        logic [CH_W-1:0] gam_v;

        assign over  = (pix[c] >> CH_W) != '0;
        assign rd_idx[c] = {1'b0, pix[c][CH_W-1 -: AW-1]};
        assign deg_v = chan_of(rd_ent[c], c);

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_over <= 1'b0;
                s1_val  <= '0;
            end else if (pix_valid) begin
                s1_over <= over;
                s1_val  <= (mode == MODE_SPLIT) ? deg_v : pix[c][CH_W-1:0];
            end
        end

        assign rd_idx[NCH+c] = (s1_mode == MODE_SPLIT)
                             ? {1'b1, s1_val[CH_W-1 -: AW-1]}
                             : s1_val[CH_W-1 -: AW];
        assign gam_v = chan_of(rd_ent[NCH+c], c);

        always_ff @(posedge clk) begin
            if (rst)
                out_v[c] <= '0;
            else if (s1_valid) begin
                if (s1_over)
                    out_v[c] <= max_v[c];
                else if (is_legacy(s1_mode))
                    out_v[c] <= {gam_v[CH_W-1 -: 8], {PAD_LEG{1'b0}}};
                else
                    out_v[c] <= {gam_v, {PAD_FULL{1'b0}}};
            end
        end

        if (CH_W > AW) begin : g_sink
            logic unused_lo;
            assign unused_lo = ^s1_val[CH_W-AW-1:0];
        end

        // R10: out-of-range code returns the channel maximum
        p_clamp_max_r10: assert property (@(posedge clk) disable iff (rst)
            (pix_valid && over) |=> ##1 (out_v[c] == $past(max_v[c])));

        // R7: full mode result carries ten significant bits
        p_full_pad_r7: assert property (@(posedge clk) disable iff (rst)
            (pix_valid && !over && (mode == MODE_FULL10))
            |=> ##1 (out_v[c][PAD_FULL-1:0] == '0));

        // R9: legacy result carries eight significant bits
        p_legacy_pad_r9: assert property (@(posedge clk) disable iff (rst)
            (pix_valid && !over && is_legacy(mode))
            |=> ##1 (out_v[c][PAD_LEG-1:0] == '0));
    end

    // R12: fixed two-cycle latency
    p_latency_r12: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> ##1 out_valid);
    p_no_spurious_r12: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> ##1 !out_valid);

endmodule

// File: rtl/gamma_split_palette.sv
module gamma_split_palette
    import gsp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IN_W  = CH_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             pix_valid,
    input  logic [IN_W-1:0]  pix_r,
    input  logic [IN_W-1:0]  pix_g,
    input  logic [IN_W-1:0]  pix_b,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_r,
    output logic [OUT_W-1:0] out_g,
    output logic [OUT_W-1:0] out_b
);

    localparam int AW  = $clog2(DEPTH);
    localparam int NLK = 2 * NCH;
    localparam int NRD = NLK + 1;

    logic             mem_we;
    logic [AW-1:0]    mem_widx;
    rgb_t             mem_wdata;
    logic [AW-1:0]    reg_ridx;
    rgb_t             reg_rent;
    mode_e            mode;
    logic [OUT_W-1:0] max_v [NCH];
    logic [IN_W-1:0]  pix [NCH];
    logic [OUT_W-1:0] out_v [NCH];
    logic [AW-1:0]    lk_idx [NLK];
    rgb_t             lk_ent [NLK];
    logic [AW-1:0]    all_idx [NRD];
    rgb_t             all_ent [NRD];

    assign pix[0] = pix_r;
    assign pix[1] = pix_g;
    assign pix[2] = pix_b;
    assign out_r  = out_v[0];
    assign out_g  = out_v[1];
    assign out_b  = out_v[2];

    for (genvar p = 0; p < NLK; p++) begin : g_port
        assign all_idx[p] = lk_idx[p];
        assign lk_ent[p]  = all_ent[p];
    end
    assign all_idx[NLK] = reg_ridx;
    assign reg_rent     = all_ent[NLK];

    gsp_ctrl_regs #(.DEPTH(DEPTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .mem_we    (mem_we),
        .mem_widx  (mem_widx),
        .mem_wdata (mem_wdata),
        .mem_ridx  (reg_ridx),
        .mem_rent  (reg_rent),
        .mode      (mode),
        .max_v     (max_v)
    );

    gsp_lut_mem #(.DEPTH(DEPTH), .NRD(NRD)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mem_we),
        .wr_idx  (mem_widx),
        .wr_data (mem_wdata),
        .rd_idx  (all_idx),
        .rd_data (all_ent)
    );

    gsp_lookup #(.DEPTH(DEPTH), .IN_W(IN_W)) u_look (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .max_v     (max_v),
        .pix_valid (pix_valid),
        .pix       (pix),
        .rd_idx    (lk_idx),
        .rd_ent    (lk_ent),
        .out_valid (out_valid),
        .out_v     (out_v)
    );

endmodule

// File: tb/gamma_split_palette_test.sv
`timescale 1ns/1ps
module gamma_split_palette_test;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid = 1'b0;
    logic [10:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_valid;
    logic [15:0] out_r, out_g, out_b;

    int checks = 0;
    int errors = 0;

    logic [29:0] model [DEPTH];
    logic [5:0]  bidx;
    logic        bauto, bsplit;
    logic [1:0]  cur_mode;
    logic [15:0] cur_max [3];

    always #4 clk = ~clk;

    gamma_split_palette uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .out_valid(out_valid),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] ch(input logic [29:0] w, input int c);
        return (c == 0) ? w[29:20] : (c == 1) ? w[19:10] : w[9:0];
    endfunction

    function automatic logic [15:0] expv(input logic [10:0] code, input int c);
        logic [9:0] d, g;
        if (code[10]) return cur_max[c];
        if (cur_mode == 2'd2) begin
            d = ch(model[{1'b0, code[9:5]}], c);
            g = ch(model[{1'b1, d[9:5]}], c);
            return {g, 6'b0};
        end
        g = ch(model[code[9:4]], c);
        if (cur_mode == 2'd1) return {g, 6'b0};
        return {g[9:2], 8'b0};
    endfunction

    function automatic logic [31:0] exp_idx();
        return {bsplit, 15'b0, bauto, 9'b0, bidx};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            3'd0: begin bidx = d[5:0]; bauto = d[15]; bsplit = d[31]; end
            3'd1: begin
                model[bidx] = d[29:0];
                if (bauto) bidx = bsplit ? {bidx[5], bidx[4:0] + 5'd1} : bidx + 6'd1;
            end
            3'd2: cur_mode = d[1:0];
            3'd4, 3'd5, 3'd6: cur_max[a - 3'd4] = d[15:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic look(input string req, input logic [10:0] r, input logic [10:0] g, input logic [10:0] b);
        logic [15:0] er, eg, eb;
        er = expv(r, 0); eg = expv(g, 1); eb = expv(b, 2);
        @(negedge clk);
        pix_r = r; pix_g = g; pix_b = b; pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        chk("R12 early", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R12 valid", {31'b0, out_valid}, 32'd1);
        chk({req, " red"},   {16'b0, out_r}, {16'b0, er});
        chk({req, " green"}, {16'b0, out_g}, {16'b0, eg});
        chk({req, " blue"},  {16'b0, out_b}, {16'b0, eb});
    endtask

    function automatic logic [10:0] rcode();
        return 11'($urandom % 1024);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1357));
        for (int i = 0; i < DEPTH; i++) begin
            logic [9:0] l;
            l = 10'((i * 1023) / (DEPTH - 1));
            model[i] = {l, l, l};
        end
        bidx = 0; bauto = 0; bsplit = 0; cur_mode = 0;
        for (int c = 0; c < 3; c++) cur_max[c] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); chk("R1 index", v, 32'd0);
        rd(3'd2, v); chk("R1 mode", v, 32'd0);
        for (int c = 0; c < 3; c++) begin
            rd(3'(4 + c), v); chk("R1 max", v, 32'h0000FFFF);
        end
        rd(3'd1, v); chk("R1 entry0", v, {2'b0, model[0]});
        wr(3'd0, 32'd21); rd(3'd1, v); chk("R1 entry21", v, {2'b0, model[21]});
        wr(3'd0, 32'd63); rd(3'd1, v); chk("R1 entry63", v, {2'b0, model[63]});
        rd(3'd0, v); chk("R2 read keeps index", v, exp_idx());

        // R9 legacy on reset ramp
        for (int k = 0; k < 4; k++) look("R9 ramp", rcode(), rcode(), rcode());

        // R3/R4 full burst load
        wr(3'd0, 32'h0000_8000);
        for (int k = 0; k < DEPTH; k++) wr(3'd1, $urandom & 32'h3FFF_FFFF);
        rd(3'd0, v); chk("R4 wrap to zero", v, 32'h0000_8000);
        for (int k = 0; k < 4; k++) begin
            logic [5:0] x;
            x = 6'($urandom % DEPTH);
            wr(3'd0, {26'b0, x}); rd(3'd1, v); chk("R2 readback", v, {2'b0, model[x]});
        end

        // R3 hold without auto-increment
        wr(3'd0, 32'd5);
        wr(3'd1, 32'h1234_5678); wr(3'd1, 32'h0ABC_DEF1);
        rd(3'd0, v); chk("R3 hold index", v, 32'd5);
        rd(3'd1, v); chk("R2 packing", v, 32'h0ABC_DEF1);
        wr(3'd0, 32'h0000_800A);
        for (int k = 0; k < 3; k++) wr(3'd1, $urandom & 32'h3FFF_FFFF);
        rd(3'd0, v); chk("R3 step", v, 32'h0000_800D);

        // R6 field positions
        wr(3'd0, 32'h8000_8003); rd(3'd0, v); chk("R6 fields", v, 32'h8000_8003);

        // R5 split segment wrap
        wr(3'd0, 32'h8000_8000);
        for (int k = 0; k < 40; k++) wr(3'd1, $urandom & 32'h3FFF_FFFF);
        rd(3'd0, v); chk("R5 lower wrap", v, exp_idx());
        chk("R5 lower idx", v & 32'h3F, 32'd8);
        wr(3'd0, 32'h8000_8020);
        for (int k = 0; k < 33; k++) wr(3'd1, $urandom & 32'h3FFF_FFFF);
        rd(3'd0, v); chk("R5 upper wrap", v & 32'h3F, 32'd33);
        wr(3'd0, 32'd0); rd(3'd0, v); chk("R6 return to zero", v, 32'd0);

        // R7 full mode
        wr(3'd2, 32'd1); rd(3'd2, v); chk("R11 mode read", v, 32'd1);
        for (int k = 0; k < 16; k++) look("R7 full", rcode(), rcode(), rcode());
        look("R7 full edge", 11'd0, 11'd1023, 11'd512);

        // R8 split cascade
        wr(3'd2, 32'd2);
        for (int k = 0; k < 16; k++) look("R8 split", rcode(), rcode(), rcode());
        look("R8 split edge", 11'd1023, 11'd0, 11'd31);

        // R9 / R11 legacy and alias
        wr(3'd2, 32'd0);
        for (int k = 0; k < 8; k++) look("R9 legacy", rcode(), rcode(), rcode());
        wr(3'd2, 32'd3);
        for (int k = 0; k < 8; k++) look("R11 alias", rcode(), rcode(), rcode());

        // R10 clamp above 1.0
        for (int c = 0; c < 3; c++) begin
            wr(3'(4 + c), $urandom);
            rd(3'(4 + c), v); chk("R10 max read", v, {16'b0, cur_max[c]});
        end
        look("R10 all over", 11'd1024, 11'd2047, 11'd1500);
        wr(3'd2, 32'd2);
        for (int k = 0; k < 8; k++)
            look("R10 mixed", rcode() | 11'(($urandom % 2) << 10),
                 rcode() | 11'(($urandom % 2) << 10), rcode());
        wr(3'd2, 32'd1);
        look("R10 full edge", 11'd1023, 11'd1024, 11'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule